// File: doc/BRIEF.md
# I2C Serial Clock Phase Timer

This block times the serial clock of an I2C bus master. From the core clock it produces the drive-low request for SCL and two one-cycle phase markers that a data shifter uses to launch and sample bits. The phase lengths come from a 12-bit divider value and two mode bits. Standard rate gives equal low and high phases. Fast rate gives either a 2:1 or a 16:9 low-to-high ratio.

After SCL is released, the block waits for the sensed line to read high before it starts the high phase. A slow rise or a target that holds the clock low therefore lengthens the cycle instead of shortening the high time. A programmed rise-time budget sets how long this wait may last before a stretch indication is raised. The block keeps waiting, with no time limit, until the line reads high.

The divider, the mode bits and the rise budget are sampled only while the run input is low. While run is high, changes on these inputs have no effect.

Top module: `scl_timer`

## Requirements
- R1: While reset is asserted, and in every cycle after a clock edge that saw `run` low, `scl_low`, `strb_low`, `strb_high` and `stretch` are all 0.
- R2: In standard rate (`cfg_fast`=0), the low phase and the high phase each last D core cycles, where D is the divider value.
- R3: In fast rate with `cfg_duty`=0, the low phase lasts 2·D cycles and the high phase lasts D cycles.
- R4: In fast rate with `cfg_duty`=1, the low phase lasts 16·D cycles and the high phase lasts 9·D cycles.
- R5: D is the programmed divider raised to a floor. The floor is 4 in standard rate and 1 in fast rate. Divider values of 4095 and below are used unchanged when they are at or above the floor.
- R6: After the low phase ends, the block releases SCL and waits in a release state. The high phase starts on the edge after `scl_in` is sampled at 1, so with an instant loopback the release state lasts one cycle. While `scl_in` stays 0, the block neither drives SCL low nor starts the high phase.
- R7: `stretch` is 1 in every release-state cycle whose index, counted from 0, is at least `cfg_rise`. It is 0 in all other cycles.
- R8: The divider, the mode bits and the rise budget are captured only on edges where `run` is 0. Changes while `run` is 1 do not affect the phase lengths.
- R9: `strb_low` is 1 only in the first cycle of each low phase. `strb_high` is 1 only in the first cycle of each high phase. The two are never 1 together.
- R10: In the first cycle after the edge that first sees `run` at 1, a low phase begins, with `scl_low`=1 and `strb_low`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Clock generation enable; configuration is captured while low |
| cfg_div | input | 12 | Divider value |
| cfg_fast | input | 1 | 1 selects fast rate |
| cfg_duty | input | 1 | In fast rate, 1 selects the 16:9 ratio |
| cfg_rise | input | 6 | Rise-time budget in core cycles |
| scl_in | input | 1 | Sensed level of SCL |
| scl_low | output | 1 | 1 requests that SCL be pulled low |
| strb_low | output | 1 | Marks the first cycle of a low phase |
| strb_high | output | 1 | Marks the first cycle of a high phase |
| stretch | output | 1 | Release wait has run past the rise budget |

## Verification
Two events can fall in the same cycle: the end of the release wait (`scl_in` seen high) and the crossing of the rise budget, which raises `stretch`. The bench holds the sensed line low while the stretch count passes the budget, then releases it. It checks that `stretch` is on at the expected indices, that no high marker appears during the hold, and that the high phase after the release still has its full length. A second overlap is a configuration change that arrives while `run` is high. The bench checks that the next measured low phase keeps the old length and that the new value takes effect only after `run` has been low.

// File: rtl/scl_timer.sv
module scl_timer #(
  parameter int DIV_W   = 12,
  parameter int RISE_W  = 6,
  parameter int STD_MIN = 4,
  parameter int FST_MIN = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_fast,
  input  logic              cfg_duty,
  input  logic [RISE_W-1:0] cfg_rise,
  input  logic              scl_in,
  output logic              scl_low,
  output logic              strb_low,
  output logic              strb_high,
  output logic              stretch
);
  localparam int CNT_W = DIV_W + 4;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_REL, S_HIGH} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [DIV_W-1:0]  div_q;
  logic              fast_q, duty_q;
  logic [RISE_W-1:0] rise_q;
  logic [CNT_W-1:0]  d_eff, low_len, high_len;

  always_comb begin
    d_eff = CNT_W'(div_q);
    if (fast_q  && div_q < DIV_W'(FST_MIN)) d_eff = CNT_W'(FST_MIN);
    if (!fast_q && div_q < DIV_W'(STD_MIN)) d_eff = CNT_W'(STD_MIN);
  end

  assign low_len  = !fast_q ? d_eff : (duty_q ? d_eff << 4 : d_eff << 1);
  assign high_len = (fast_q && duty_q) ? (d_eff << 3) + d_eff : d_eff;

  assign scl_low  = (st == S_LOW);
  assign stretch  = (st == S_REL) && (cnt >= CNT_W'(rise_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      div_q     <= '0;
      fast_q    <= 1'b0;
      duty_q    <= 1'b0;
      rise_q    <= '0;
      strb_low  <= 1'b0;
      strb_high <= 1'b0;
    end else begin
      strb_low  <= 1'b0;
      strb_high <= 1'b0;
      if (!run) begin
        div_q  <= cfg_div;
        fast_q <= cfg_fast;
        duty_q <= cfg_duty;
        rise_q <= cfg_rise;
        st     <= S_IDLE;
        cnt    <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            st       <= S_LOW;
            cnt      <= low_len - 1'b1;
            strb_low <= 1'b1;
          end
          S_LOW: begin
            if (cnt == '0) st <= S_REL;
            else           cnt <= cnt - 1'b1;
          end
          S_REL: begin
            if (scl_in) begin
              st        <= S_HIGH;
              cnt       <= high_len - 1'b1;
              strb_high <= 1'b1;
            end else if (cnt != '1) begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (cnt == '0) begin
              st       <= S_LOW;
              cnt      <= low_len - 1'b1;
              strb_low <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/scl_timer_chk.sv
module scl_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic scl_in,
  input logic scl_low,
  input logic strb_low,
  input logic strb_high,
  input logic stretch
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!scl_low && !strb_low && !strb_high && !stretch));

  a_r9_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb_low && strb_high));

  a_r9_low_strobe_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    strb_low |-> scl_low);

  a_r7_stretch_released: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |-> !scl_low);

  a_r6_high_after_sense: assert property (@(posedge clk) disable iff (!rst_n)
    strb_high |-> $past(scl_in));

  a_r6_hold_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch && !scl_in && run) |=> (!strb_high && !scl_low));

  a_r10_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> (scl_low && strb_low));
endmodule

bind scl_timer scl_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .scl_in(scl_in),
  .scl_low(scl_low), .strb_low(strb_low), .strb_high(strb_high),
  .stretch(stretch)
);

// File: tb/scl_timer_tb.sv
module scl_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [11:0] cfg_div = '0;
  logic        cfg_fast = 1'b0;
  logic        cfg_duty = 1'b0;
  logic [5:0]  cfg_rise = '0;
  logic        hold = 1'b0;
  logic        scl_in;
  logic        scl_low, strb_low, strb_high, stretch;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign scl_in = ~scl_low & ~hold;

  scl_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_div(cfg_div),
    .cfg_fast(cfg_fast), .cfg_duty(cfg_duty), .cfg_rise(cfg_rise),
    .scl_in(scl_in), .scl_low(scl_low), .strb_low(strb_low),
    .strb_high(strb_high), .stretch(stretch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int deff(input int div, input bit fast);
    if (fast) return (div < 1) ? 1 : div;
    return (div < 4) ? 4 : div;
  endfunction

  function automatic int exp_low(input int div, input bit fast, input bit duty);
    int d = deff(div, fast);
    if (!fast) return d;
    return duty ? 16 * d : 2 * d;
  endfunction

  function automatic int exp_high(input int div, input bit fast, input bit duty);
    int d = deff(div, fast);
    return (fast && duty) ? 9 * d : d;
  endfunction

  task automatic measure(output int lo, output int hi);
    int g = 0;
    lo = 0; hi = 0;
    while (!strb_low && g < 150000) begin @(negedge clk); g++; end
    while (scl_low && g < 150000) begin lo++; @(negedge clk); g++; end
    while (!strb_high && g < 150000) begin @(negedge clk); g++; end
    while (!strb_low && g < 150000) begin hi++; @(negedge clk); g++; end
  endtask

  task automatic start(input int div, input bit fast, input bit duty, input int rise);
    run = 1'b0;
    cfg_div = 12'(div); cfg_fast = fast; cfg_duty = duty; cfg_rise = 6'(rise);
    @(negedge clk); @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    chk(scl_low && strb_low, "R10 start low", {scl_low, strb_low}, 3);
  endtask

  task automatic sweep(input int div, input bit fast, input bit duty, input string tag);
    int lo, hi;
    start(div, fast, duty, 10);
    measure(lo, hi);
    chk(lo == exp_low(div, fast, duty), {tag, " low"}, lo, exp_low(div, fast, duty));
    chk(hi == exp_high(div, fast, duty), {tag, " high"}, hi, exp_high(div, fast, duty));
    measure(lo, hi);
    chk(lo == exp_low(div, fast, duty), {tag, " low2"}, lo, exp_low(div, fast, duty));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000 && !done) begin
        done = 1'b1;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int lo, hi;
    @(negedge clk);
    chk(!scl_low && !strb_low && !strb_high && !stretch, "R1 reset",
        {scl_low, strb_low, strb_high, stretch}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_low && !stretch, "R1 idle", {scl_low, stretch}, 0);

    for (int d = 0; d <= 10; d++) sweep(d, 1'b0, 1'b0, (d < 4) ? "R5 R2 std" : "R2 std");
    for (int d = 0; d <= 10; d++) sweep(d, 1'b1, 1'b0, (d < 1) ? "R5 R3 fast2" : "R3 fast2");
    for (int d = 0; d <= 5; d++)  sweep(d, 1'b1, 1'b1, (d < 1) ? "R5 R4 fast169" : "R4 fast169");
    sweep(4095, 1'b0, 1'b0, "R5 R2 std max");

    // R9: strobe placement over a few periods, checked every cycle
    start(3, 1'b1, 1'b0, 10);
    begin
      bit prev_low = 1'b1;
      bit ok = 1'b1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (strb_low && strb_high) ok = 1'b0;
        if (strb_low != (scl_low && !prev_low)) ok = 1'b0;
        prev_low = scl_low;
      end
      chk(ok, "R9 strobes", ok, 1);
    end

    // R8: change while running is ignored, taken after run low
    start(5, 1'b0, 1'b0, 10);
    cfg_div = 12'd20; cfg_fast = 1'b1; cfg_duty = 1'b1;
    measure(lo, hi);
    chk(lo == 5, "R8 ignored low", lo, 5);
    chk(hi == 5, "R8 ignored high", hi, 5);
    run = 1'b0;
    @(negedge clk);
    chk(!scl_low && !strb_low && !strb_high, "R1 run low", scl_low, 0);
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    measure(lo, hi);
    chk(lo == 320, "R8 applied low", lo, 320);
    chk(hi == 180, "R8 applied high", hi, 180);

    // R6/R7: hold the sensed line low through the budget, then release
    start(5, 1'b0, 1'b0, 3);
    hold = 1'b1;
    while (scl_low) @(negedge clk);
    begin
      bit ok6 = 1'b1;
      for (int k = 0; k < 10; k++) begin
        chk(stretch == (k >= 3), "R7 stretch index", stretch, k >= 3);
        if (scl_low || strb_high) ok6 = 1'b0;
        if (k < 9) @(negedge clk);
      end
      chk(ok6, "R6 no advance while low", ok6, 1);
    end
    hold = 1'b0;
    @(negedge clk);
    chk(strb_high && !stretch, "R6 high after release", {strb_high, stretch}, 2);
    hi = 0;
    while (!strb_low && hi < 100) begin hi++; @(negedge clk); end
    chk(hi == 5, "R6 high length after stretch", hi, 5);

    // R7: budget zero raises stretch in the first release cycle
    start(4, 1'b0, 1'b0, 0);
    hold = 1'b1;
    while (scl_low) @(negedge clk);
    chk(stretch == 1'b1, "R7 zero budget", stretch, 1);
    hold = 1'b0;
    @(negedge clk);
    chk(!stretch, "R7 cleared", stretch, 0);

    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!scl_low && !stretch, "R1 final idle", scl_low, 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule